// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a memory-mapped watchdog. A counter climbs from a programmed start value toward the top of its range. When it passes the all-ones value, the block raises a reset request. Counting is paced by a slow timer tick (`tick_i`), which stands in for a low-frequency clock. An optional power-of-two divider slows the pace further. Software keeps the system alive by writing a changed value into a trigger register. Each such write copies the start value back into the counter.

Every register write is posted. The value waits in a staging slot, and a per-register busy flag stays set until two timer ticks have passed. Only then does the write act on the timer, and only then can the same register accept a new value. Starting and stopping the timer each need two keyed writes in a fixed order, so one stray store cannot switch the watchdog off.

The bus is a plain single-cycle write port with combinational read data. Offsets are byte addresses: 0x00 revision, 0x04 control, 0x08 counter (read only), 0x0C start value, 0x10 trigger, 0x14 key, 0x18 busy flags.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the timer is stopped, the counter reads 0, the start value reads 0xFFFFF000, control reads 0, busy flags read 0, the key tracker is idle and `wdt_rst_o` is low.
- R2: Offset 0x00 returns the revision number in bits 7:0 with zeros above. Control at 0x04 reads back its committed fields: bit 5 enables the divider and bits 4:2 hold the divider exponent.
- R3: A write sets its busy bit at offset 0x18 on the next clock: bit 0 for control, bit 2 for start value, bit 3 for trigger, bit 4 for key. The bit clears on the second timer tick after the write. The written value takes effect on that same edge and not before.
- R4: A write to a register whose busy bit is set is discarded.
- R5: A trigger write whose value differs from the last committed trigger value loads the start value into the counter. A trigger write with the same value leaves the counter alone.
- R6: Key values 0xBBBB and then 0x4444, compared on bits 15:0 and each committed, start the timer. The same values in the other order do not.
- R7: Key values 0xAAAA and then 0x5555 stop the timer. While stopped, the counter holds its value across ticks.
- R8: A committed first key followed by any other committed key value abandons the sequence. The next key must begin again from a first key.
- R9: While running with the divider off, the counter rises by one on each tick. With the divider on and exponent p, it rises once per 2^p ticks. The divider phase restarts when control commits.
- R10: A step from 0xFFFFFFFF loads the start value into the counter and drives `wdt_rst_o` high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick enable, one clock wide per tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_rst_o | output | 1 | One-clock reset request on overflow |

## Verification
A wrong busy-flag age or a slot that keeps accepting writes shows up at offset 0x18 within a tick or two. A value read back too early or too late shows up in the same window. A key tracker stuck in an armed state only becomes visible when a later key write starts or stops the timer. The bench therefore reads the counter across several ticks after every key sequence. A divider phase fault reveals itself only at the end of a full 2^p-tick period, so the prescaled checks span two complete periods and one period less a tick. An overflow fault appears on the very clock after the wrapping tick, as a missing or stretched reset pulse or a wrong counter value.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int PTV_W  = 3;
  localparam int KEY_W  = 16;
  localparam int SETTLE = 2;

  localparam logic [ADDR_W-1:0] OFF_REV   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_LOAD  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_TRIG  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_KEY   = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_BUSY  = 5'h18;

  localparam logic [KEY_W-1:0] KEY_ON1  = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_ON2  = 16'h4444;
  localparam logic [KEY_W-1:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OFF2 = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE    = 2'd0,
    KS_ARM_ON  = 2'd1,
    KS_ARM_OFF = 2'd2
  } key_state_t;
endpackage

// File: rtl/kwd_post.sv
module kwd_post #(
  parameter int W      = 32,
  parameter int SETTLE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] data
);
  localparam int AGE_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  logic         busy_q, busy_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic [W-1:0] data_q, data_d;
  logic         commit_d;

  always_comb begin
    busy_d   = busy_q;
    age_d    = age_q;
    data_d   = data_q;
    commit_d = 1'b0;
    if (!busy_q) begin
      if (wr_hit) begin
        busy_d = 1'b1;
        age_d  = '0;
        data_d = wdata;
      end
    end else if (tick) begin
      if (age_q == AGE_W'(SETTLE - 1)) begin
        busy_d   = 1'b0;
        commit_d = 1'b1;
      end else begin
        age_d = age_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      age_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      age_q  <= age_d;
      data_q <= data_d;
    end
  end

  assign busy   = busy_q;
  assign commit = commit_d;
  assign data   = data_q;

  // R4: a write landing on a busy slot leaves the staged value untouched
  assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_hit) |=> $stable(data_q));
  // R3: a busy flag only drops on a timer tick
  assert_clear_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tick));
  // R3: an accepted write raises the flag on the next clock
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && wr_hit) |=> busy_q);
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [KEY_W-1:0] key,
  output logic             run
);
  key_state_t st_q, st_d;
  logic       run_q, run_d;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (commit) begin
      unique case (st_q)
        KS_ARM_ON: begin
          if (key == KEY_ON2) run_d = 1'b1;
          st_d = KS_IDLE;
        end
        KS_ARM_OFF: begin
          if (key == KEY_OFF2) run_d = 1'b0;
          st_d = KS_IDLE;
        end
        default: begin
          if (key == KEY_ON1)       st_d = KS_ARM_ON;
          else if (key == KEY_OFF1) st_d = KS_ARM_OFF;
          else                      st_d = KS_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      run_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign run = run_q;

  // R6: run state changes only on a committed key write
  assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(run_q));
  // R6: starting requires a prior first key
  assert_start_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(st_q == KS_ARM_ON));
  // R7: stopping requires a prior first stop key
  assert_stop_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(st_q == KS_ARM_OFF));
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             ps_clr,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wdt_rst
);
  localparam int DIV_W = (1 << PTV_W) - 1;

  logic [DIV_W-1:0] ps_q, ps_d, ps_lim;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_q, rst_d;
  logic             ps_hit, step;

  assign ps_lim = (DIV_W'(1) << ptv) - DIV_W'(1);
  assign ps_hit = (ps_q == ps_lim);
  assign step   = run && tick && (!pre_en || ps_hit);

  always_comb begin
    ps_d = ps_q;
    if (ps_clr || reload || !run) ps_d = '0;
    else if (tick && pre_en)      ps_d = ps_hit ? '0 : ps_q + 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q;
    rst_d = 1'b0;
    if (reload) begin
      cnt_d = load_val;
    end else if (step) begin
      if (&cnt_q) begin
        cnt_d = load_val;
        rst_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      ps_q  <= ps_d;
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign cnt     = cnt_q;
  assign wdt_rst = rst_q;

  // R10: the reset request lasts a single clock
  assert_pulse_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  // R10: the request coincides with the counter holding the start value
  assert_wrap_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (cnt_q == $past(load_val)));
  // R7: a stopped timer without reload keeps its count
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cnt_q));
  // R9: without a tick the count does not advance
  assert_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter logic [7:0]        REV_ID   = 8'h31,
  parameter logic [DATA_W-1:0] RST_LOAD = 32'hFFFFF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_o
);
  localparam int CTRL_W = PTV_W + 1;

  logic hit_ctrl, hit_load, hit_trig, hit_key;
  logic busy_ctrl, busy_load, busy_trig, busy_key;
  logic com_ctrl, com_load, com_trig, com_key;
  logic [CTRL_W-1:0] stg_ctrl;
  logic [DATA_W-1:0] stg_load, stg_trig;
  logic [KEY_W-1:0]  stg_key;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] load_q, load_d, trig_q, trig_d;
  logic              reload, run;
  logic [DATA_W-1:0] cnt;

  assign hit_ctrl = bus_wr && (bus_addr == OFF_CTRL);
  assign hit_load = bus_wr && (bus_addr == OFF_LOAD);
  assign hit_trig = bus_wr && (bus_addr == OFF_TRIG);
  assign hit_key  = bus_wr && (bus_addr == OFF_KEY);

  kwd_post #(.W(CTRL_W), .SETTLE(SETTLE)) u_post_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr_hit(hit_ctrl),
    .wdata(bus_wdata[5:2]), .busy(busy_ctrl), .commit(com_ctrl), .data(stg_ctrl));
  kwd_post #(.W(DATA_W), .SETTLE(SETTLE)) u_post_load (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr_hit(hit_load),
    .wdata(bus_wdata), .busy(busy_load), .commit(com_load), .data(stg_load));
  kwd_post #(.W(DATA_W), .SETTLE(SETTLE)) u_post_trig (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr_hit(hit_trig),
    .wdata(bus_wdata), .busy(busy_trig), .commit(com_trig), .data(stg_trig));
  kwd_post #(.W(KEY_W), .SETTLE(SETTLE)) u_post_key (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .wr_hit(hit_key),
    .wdata(bus_wdata[KEY_W-1:0]), .busy(busy_key), .commit(com_key), .data(stg_key));

  always_comb begin
    ctrl_d = com_ctrl ? stg_ctrl : ctrl_q;
    load_d = com_load ? stg_load : load_q;
    trig_d = com_trig ? stg_trig : trig_q;
  end

  assign reload = com_trig && (stg_trig != trig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= RST_LOAD;
      trig_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      trig_q <= trig_d;
    end
  end

  kwd_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .commit(com_key), .key(stg_key), .run(run));

  kwd_count #(.CNT_W(DATA_W), .PTV_W(PTV_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(run),
    .pre_en(ctrl_q[CTRL_W-1]), .ptv(ctrl_q[PTV_W-1:0]), .ps_clr(com_ctrl),
    .reload(reload), .load_val(load_q), .cnt(cnt), .wdt_rst(wdt_rst_o));

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_REV:   bus_rdata = {{(DATA_W-8){1'b0}}, REV_ID};
      OFF_CTRL:  bus_rdata = {{(DATA_W-6){1'b0}}, ctrl_q, 2'b00};
      OFF_COUNT: bus_rdata = cnt;
      OFF_LOAD:  bus_rdata = load_q;
      OFF_TRIG:  bus_rdata = trig_q;
      OFF_BUSY:  bus_rdata = {{(DATA_W-5){1'b0}}, busy_key, busy_trig,
                              busy_load, 1'b0, busy_ctrl};
      default:   bus_rdata = '0;
    endcase
  end

  // R5: the counter reload follows a committed, changed trigger value
  assert_trig_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(load_q)));
  // R3: the start value changes only when its slot commits
  assert_load_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !com_load |=> $stable(load_q));
endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;
  int          n_run = 0;
  int          n_fail = 0;

  localparam logic [4:0] A_REV = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08,
                         A_LOAD = 5'h0C, A_TRIG = 5'h10, A_KEY = 5'h14,
                         A_BUSY = 5'h18;

  always #10 clk = ~clk;

  keyed_wdog u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic wr_settle(input logic [4:0] a, input logic [31:0] d);
    wr(a, d);
    ticks(2);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CNT, v);  chk("R1 count", v, 32'h0);
    rd(A_LOAD, v); chk("R1 load", v, 32'hFFFFF000);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_BUSY, v); chk("R1 busy", v, 32'h0);
    chk("R1 rst out", {31'b0, wdt_rst_o}, 32'h0);
    rd(A_REV, v);  chk("R2 revision", v, 32'h31);
  endtask

  task automatic t_posted;
    logic [31:0] v;
    wr(A_LOAD, 32'h100);
    rd(A_BUSY, v); chk("R3 load busy bit2", v, 32'h04);
    wr(A_LOAD, 32'h200);
    rd(A_LOAD, v); chk("R3 no early effect", v, 32'hFFFFF000);
    ticks(1);
    rd(A_BUSY, v); chk("R3 busy after one tick", v, 32'h04);
    ticks(1);
    rd(A_BUSY, v); chk("R3 busy cleared", v, 32'h0);
    rd(A_LOAD, v); chk("R4 busy write dropped", v, 32'h100);
    wr(A_CTRL, 32'h0);
    rd(A_BUSY, v); chk("R3 ctrl busy bit0", v, 32'h01);
    ticks(2);
    wr(A_KEY, 32'h0);
    rd(A_BUSY, v); chk("R3 key busy bit4", v, 32'h10);
    ticks(2);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    wr(A_TRIG, 32'h1234);
    rd(A_BUSY, v); chk("R3 trig busy bit3", v, 32'h08);
    ticks(2);
    rd(A_CNT, v); chk("R5 changed trigger reloads", v, 32'h100);
    wr_settle(A_LOAD, 32'h500);
    wr_settle(A_TRIG, 32'h1234);
    rd(A_CNT, v); chk("R5 same trigger no reload", v, 32'h100);
    wr_settle(A_TRIG, ~32'h1234);
    rd(A_CNT, v); chk("R5 complement reloads", v, 32'h500);
  endtask

  task automatic t_start;
    logic [31:0] v;
    wr_settle(A_KEY, 32'h4444);
    wr_settle(A_KEY, 32'hBBBB);
    wr_settle(A_KEY, 32'h5555);
    ticks(3);
    rd(A_CNT, v); chk("R6 wrong order stays stopped", v, 32'h500);
    wr_settle(A_KEY, 32'hBBBB);
    wr_settle(A_KEY, 32'h1234);
    wr_settle(A_KEY, 32'h4444);
    ticks(3);
    rd(A_CNT, v); chk("R8 aborted sequence", v, 32'h500);
    wr_settle(A_KEY, 32'hBBBB);
    wr_settle(A_KEY, 32'h4444);
    rd(A_CNT, v); chk("R6 start edge no step", v, 32'h500);
    ticks(5);
    rd(A_CNT, v); chk("R9 one step per tick", v, 32'h505);
  endtask

  task automatic t_prescale;
    logic [31:0] v, c0;
    wr_settle(A_CTRL, 32'h2C);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h2C);
    rd(A_CNT, c0);
    ticks(16);
    rd(A_CNT, v); chk("R9 two periods of 8", v, c0 + 2);
    ticks(7);
    rd(A_CNT, v); chk("R9 period not done", v, c0 + 2);
    ticks(1);
    rd(A_CNT, v); chk("R9 period done", v, c0 + 3);
  endtask

  task automatic t_stop;
    logic [31:0] v, c0;
    wr_settle(A_KEY, 32'hAAAA);
    wr_settle(A_KEY, 32'h5555);
    rd(A_CNT, c0);
    ticks(20);
    rd(A_CNT, v); chk("R7 stopped holds", v, c0);
    wr_settle(A_CTRL, 32'h0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr_settle(A_LOAD, 32'hFFFFFFFD);
    wr_settle(A_TRIG, 32'h1234);
    rd(A_CNT, v); chk("R5 reload before run", v, 32'hFFFFFFFD);
    wr_settle(A_KEY, 32'hBBBB);
    wr_settle(A_KEY, 32'h4444);
    ticks(2);
    rd(A_CNT, v); chk("R10 at top", v, 32'hFFFFFFFF);
    chk("R10 no early pulse", {31'b0, wdt_rst_o}, 32'h0);
    ticks(1);
    rd(A_CNT, v); chk("R10 wrap reloads", v, 32'hFFFFFFFD);
    chk("R10 pulse high", {31'b0, wdt_rst_o}, 32'h1);
    @(negedge clk);
    chk("R10 pulse one clock", {31'b0, wdt_rst_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_posted();
    t_trigger();
    t_start();
    t_prescale();
    t_stop();
    t_overflow();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule